// File: doc/BRIEF.md
# Interleaved YCbCr Progressive Input Demultiplexer

This block accepts 4:2:2 progressive-scan video that arrives time-multiplexed on one 10-bit word bus in the repeating order Cb, Y, Cr, Y. It turns that stream into parallel luma and chroma words with a one-cycle valid strobe. The bus can be captured in two ways. In one, a 27 MHz clock samples it on both edges. In the other, a 54 MHz clock samples it on rising edges only. In dual-edge capture a configuration input states whether the chroma sample or the luma sample of each pair lands on the rising edge.

Each line carries embedded timing reference codes: a header of all-ones, zero, zero, followed by a status word. The block finds these codes, keeps them off the pixel output, and decodes the status word into field, vertical-blank and horizontal (start/end of active video) flags. A start-of-active-video code realigns the chroma sequencer so that the next pair carries Cb. The bus can also be driven with only its upper 8 bits meaningful, in which case the two low bits are discarded.

Top module: `ycbcr_ilv_demux`

## Requirements
- R1: With mode_i = 3'b111, one word is captured per rising edge, and consecutive words are grouped into (chroma, luma) pairs. A header word (all ones) always starts a new pair.
- R2: With mode_i = 3'b100, one word is captured on each rising edge and one on each falling edge, and the two words captured around one clock period form one pair.
- R3: In dual-edge capture, y_on_rise_i = 0 means the chroma word is taken on a rising edge and the luma word on the following falling edge. y_on_rise_i = 1 means the chroma word is taken on a falling edge and the luma word on the following rising edge.
- R4: Any other value of mode_i captures nothing, and valid_o stays low once the pipeline has drained.
- R5: The four words 3FF, 000, 000, XY form a timing reference code. From the XY word, bit 8 sets field_o, bit 7 sets vblank_o and bit 6 sets hflag_o (0 = start, 1 = end of active video). The flags hold until the next XY word.
- R6: valid_o never pulses for the words of a timing reference code.
- R7: After a start-of-active-video code, the next output pair is marked Cb (c_is_cr_o = 0).
- R8: Each data pair gives one valid_o pulse with c_o = first word and y_o = second word. c_is_cr_o alternates, 0 for Cb and 1 for Cr.
- R9: With narrow_i = 1, the two low bits of every captured word are forced to zero, and a header is recognised from the upper 8 bits being all ones.
- R10: After reset, valid_o, c_is_cr_o, field_o, vblank_o and hflag_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock (27 MHz dual-edge or 54 MHz single-edge) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Capture mode: 3'b100 dual-edge, 3'b111 single-edge, other values idle |
| y_on_rise_i | input | 1 | Dual-edge phase: 1 = luma on rising edge |
| narrow_i | input | 1 | 1 = only the upper 8 bits of the bus carry data |
| data_i | input | DW | Interleaved word bus |
| y_o | output | DW | Luma word of the current pair |
| c_o | output | DW | Chroma word of the current pair |
| c_is_cr_o | output | 1 | 0 = c_o is Cb, 1 = c_o is Cr |
| valid_o | output | 1 | One-cycle strobe for y_o, c_o and c_is_cr_o |
| field_o | output | 1 | Field flag from the last status word |
| vblank_o | output | 1 | Vertical-blank flag from the last status word |
| hflag_o | output | 1 | 0 after start, 1 after end of active video |

## Verification
Two events can meet in the same cycle. The first is the status word of a start-of-active-video code, which resets the chroma sequencer. The second is a data pair, which advances that sequencer. The bench provokes the meeting by placing a single data pair between an end code and a start code, so the sequencer is left on Cr when the start code arrives. The first pair after the start code must then be reported as Cb, with the flags of the new code attached. A stray word ahead of the header also checks that single-edge pairing realigns on the header rather than carrying the old phase into the decode.

// File: rtl/ilv_demux_pkg.sv
`timescale 1ns/1ps
package ilv_demux_pkg;
  localparam logic [2:0] MODE_DUAL   = 3'b100;
  localparam logic [2:0] MODE_SINGLE = 3'b111;
  localparam int         HDR_W       = 8;

  typedef struct packed {
    logic field;
    logic vblank;
    logic hflag;
  } trs_flags_t;
endpackage

// File: rtl/ilv_capture.sv
`timescale 1ns/1ps
module ilv_capture
  import ilv_demux_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          y_on_rise_i,
  input  logic          narrow_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] beat_w0_o,
  output logic [DW-1:0] beat_w1_o,
  output logic          beat_vld_o,
  output logic          beat_dual_o
);
  localparam int LOW_W = DW - HDR_W;
  localparam logic [DW-1:0] KEEP_NARROW = {{HDR_W{1'b1}}, {LOW_W{1'b0}}};

  logic [DW-1:0] word_in;
  logic [DW-1:0] rise_q, fall_q, fall_d;
  logic          vld_q, dual_q, ysel_q;

  assign word_in = narrow_i ? (data_i & KEEP_NARROW) : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_d <= '0;
      vld_q  <= 1'b0;
      dual_q <= 1'b0;
      ysel_q <= 1'b0;
    end else begin
      rise_q <= word_in;
      fall_d <= fall_q;  // falling word that preceded this rising edge
      vld_q  <= (mode_i == MODE_DUAL) || (mode_i == MODE_SINGLE);
      dual_q <= (mode_i == MODE_DUAL);
      ysel_q <= y_on_rise_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= word_in;
  end

  // Beat order: chroma word first, luma word second
  always_comb begin
    if (!dual_q) begin
      beat_w0_o = rise_q;
      beat_w1_o = rise_q;
    end else if (ysel_q) begin
      beat_w0_o = fall_d;
      beat_w1_o = rise_q;
    end else begin
      beat_w0_o = rise_q;
      beat_w1_o = fall_q;
    end
  end

  assign beat_vld_o  = vld_q;
  assign beat_dual_o = dual_q;
endmodule

// File: rtl/ilv_pair.sv
`timescale 1ns/1ps
module ilv_pair
  import ilv_demux_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          narrow_i,
  input  logic [DW-1:0] beat_w0_i,
  input  logic [DW-1:0] beat_w1_i,
  input  logic          beat_vld_i,
  input  logic          beat_dual_i,
  output logic [DW-1:0] pair_w0_o,
  output logic [DW-1:0] pair_w1_o,
  output logic          pair_vld_o
);
  logic          phase_q;
  logic [DW-1:0] held_q, w0_q, w1_q;
  logic          pvld_q;
  logic          word_hdr;

  assign word_hdr = narrow_i ? (beat_w0_i[DW-1 -: HDR_W] == '1) : (beat_w0_i == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      held_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      pvld_q  <= 1'b0;
    end else begin
      pvld_q <= 1'b0;
      if (beat_vld_i) begin
        if (beat_dual_i) begin
          w0_q   <= beat_w0_i;
          w1_q   <= beat_w1_i;
          pvld_q <= 1'b1;
        end else if (word_hdr || !phase_q) begin
          // header always opens a pair: realigns single-edge pairing
          held_q  <= beat_w0_i;
          phase_q <= 1'b1;
        end else begin
          w0_q    <= held_q;
          w1_q    <= beat_w0_i;
          pvld_q  <= 1'b1;
          phase_q <= 1'b0;
        end
      end
    end
  end

  assign pair_w0_o  = w0_q;
  assign pair_w1_o  = w1_q;
  assign pair_vld_o = pvld_q;
endmodule

// File: rtl/ilv_sort.sv
`timescale 1ns/1ps
module ilv_sort
  import ilv_demux_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          narrow_i,
  input  logic [DW-1:0] pair_w0_i,
  input  logic [DW-1:0] pair_w1_i,
  input  logic          pair_vld_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o,
  output logic          c_is_cr_o,
  output logic          valid_o,
  output trs_flags_t    flags_o
);
  logic       w0_ones, w0_zero, w1_zero;
  logic       hdr_pair, xy_pair, data_pair;
  logic       pend_q, cr_next_q, sel_q, valid_q;
  logic [DW-1:0] y_q, c_q;
  trs_flags_t flags_q;

  assign w0_ones   = narrow_i ? (pair_w0_i[DW-1 -: HDR_W] == '1) : (pair_w0_i == '1);
  assign w0_zero   = (pair_w0_i == '0);
  assign w1_zero   = (pair_w1_i == '0);
  assign hdr_pair  = pair_vld_i && w0_ones && w1_zero;
  assign xy_pair   = pair_vld_i && pend_q && w0_zero;
  assign data_pair = pair_vld_i && !hdr_pair && !xy_pair;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      cr_next_q <= 1'b0;
      sel_q     <= 1'b0;
      valid_q   <= 1'b0;
      y_q       <= '0;
      c_q       <= '0;
      flags_q   <= '0;
    end else begin
      valid_q <= data_pair;
      if (pair_vld_i) pend_q <= hdr_pair;
      if (xy_pair) begin
        flags_q.field  <= pair_w1_i[DW-2];
        flags_q.vblank <= pair_w1_i[DW-3];
        flags_q.hflag  <= pair_w1_i[DW-4];
        if (!pair_w1_i[DW-4]) cr_next_q <= 1'b0;  // start of active video
      end
      if (data_pair) begin
        c_q       <= pair_w0_i;
        y_q       <= pair_w1_i;
        sel_q     <= cr_next_q;
        cr_next_q <= ~cr_next_q;
      end
    end
  end

  assign y_o       = y_q;
  assign c_o       = c_q;
  assign c_is_cr_o = sel_q;
  assign valid_o   = valid_q;
  assign flags_o   = flags_q;
endmodule

// File: rtl/ycbcr_ilv_demux.sv
`timescale 1ns/1ps
module ycbcr_ilv_demux
  import ilv_demux_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          y_on_rise_i,
  input  logic          narrow_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o,
  output logic          c_is_cr_o,
  output logic          valid_o,
  output logic          field_o,
  output logic          vblank_o,
  output logic          hflag_o
);
  logic [DW-1:0] beat_w0, beat_w1, pair_w0, pair_w1;
  logic          beat_vld, beat_dual, pair_vld;
  trs_flags_t    flags;

  ilv_capture #(.DW(DW)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .y_on_rise_i (y_on_rise_i),
    .narrow_i    (narrow_i),
    .data_i      (data_i),
    .beat_w0_o   (beat_w0),
    .beat_w1_o   (beat_w1),
    .beat_vld_o  (beat_vld),
    .beat_dual_o (beat_dual)
  );

  ilv_pair #(.DW(DW)) u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .narrow_i    (narrow_i),
    .beat_w0_i   (beat_w0),
    .beat_w1_i   (beat_w1),
    .beat_vld_i  (beat_vld),
    .beat_dual_i (beat_dual),
    .pair_w0_o   (pair_w0),
    .pair_w1_o   (pair_w1),
    .pair_vld_o  (pair_vld)
  );

  ilv_sort #(.DW(DW)) u_sort (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .narrow_i   (narrow_i),
    .pair_w0_i  (pair_w0),
    .pair_w1_i  (pair_w1),
    .pair_vld_i (pair_vld),
    .y_o        (y_o),
    .c_o        (c_o),
    .c_is_cr_o  (c_is_cr_o),
    .valid_o    (valid_o),
    .flags_o    (flags)
  );

  assign field_o  = flags.field;
  assign vblank_o = flags.vblank;
  assign hflag_o  = flags.hflag;
endmodule

// File: rtl/ycbcr_ilv_demux_chk.sv
`timescale 1ns/1ps
module ycbcr_ilv_demux_chk
  import ilv_demux_pkg::*;
#(
  parameter int DW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    mode_i,
  input logic          narrow_i,
  input logic [DW-1:0] y_o,
  input logic [DW-1:0] c_o,
  input logic          c_is_cr_o,
  input logic          valid_o,
  input logic          field_o,
  input logic          vblank_o,
  input logic          hflag_o,
  input logic          pair_vld_i,
  input logic [DW-1:0] pair_w0_i,
  input logic [DW-1:0] pair_w1_i
);
  localparam logic [DW-1:0] LOW_BITS = {{HDR_W{1'b0}}, {(DW-HDR_W){1'b1}}};

  logic [2:0] idle_cnt, sgl_cnt, nar_cnt;
  logic       nar_prev, pend_c, armed, have_last, last_sel;
  logic       hdr_c, sav_evt, nar_ok;

  assign hdr_c   = pair_vld_i && (pair_w1_i == '0) &&
                   (narrow_i ? (pair_w0_i[DW-1 -: HDR_W] == '1) : (pair_w0_i == '1));
  assign sav_evt = pair_vld_i && pend_c && (pair_w0_i == '0) && !pair_w1_i[DW-4];
  assign nar_ok  = (nar_cnt >= 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt  <= '0;
      sgl_cnt   <= '0;
      nar_cnt   <= '0;
      nar_prev  <= 1'b0;
      pend_c    <= 1'b0;
      armed     <= 1'b0;
      have_last <= 1'b0;
      last_sel  <= 1'b0;
    end else begin
      if (mode_i == MODE_DUAL || mode_i == MODE_SINGLE) idle_cnt <= '0;
      else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 3'd1;
      if (mode_i != MODE_SINGLE) sgl_cnt <= '0;
      else if (sgl_cnt != 3'd7) sgl_cnt <= sgl_cnt + 3'd1;
      nar_prev <= narrow_i;
      if (narrow_i != nar_prev) nar_cnt <= '0;
      else if (nar_cnt != 3'd7) nar_cnt <= nar_cnt + 3'd1;
      if (pair_vld_i) pend_c <= hdr_c;
      if (sav_evt) armed <= 1'b1;
      else if (valid_o) armed <= 1'b0;
      if (valid_o) begin
        have_last <= 1'b1;
        last_sel  <= c_is_cr_o;
      end
    end
  end

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt >= 3'd4) |-> !valid_o);

  assert_flags_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pair_vld_i) |-> $stable({field_o, vblank_o, hflag_o}));

  assert_trs_no_push_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_c && nar_ok) |=> !valid_o);

  assert_sav_gives_cb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && armed && nar_ok) |-> !c_is_cr_o);

  assert_chroma_alternates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && have_last && !armed && nar_ok) |-> (c_is_cr_o != last_sel));

  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sgl_cnt >= 3'd4) |=> !valid_o);

  assert_narrow_low_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && narrow_i && nar_ok) |-> (((y_o | c_o) & LOW_BITS) == '0));
endmodule

bind ycbcr_ilv_demux ycbcr_ilv_demux_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .narrow_i   (narrow_i),
  .y_o        (y_o),
  .c_o        (c_o),
  .c_is_cr_o  (c_is_cr_o),
  .valid_o    (valid_o),
  .field_o    (field_o),
  .vblank_o   (vblank_o),
  .hflag_o    (hflag_o),
  .pair_vld_i (pair_vld),
  .pair_w0_i  (pair_w0),
  .pair_w1_i  (pair_w1)
);

// File: tb/ycbcr_ilv_demux_tb.sv
`timescale 1ns/1ps
module ycbcr_ilv_demux_tb;
  localparam int DW = 10;
  localparam int N_STIM = 16;
  localparam int N_EXP = 4;
  localparam logic [2:0] M_DUAL = 3'b100;
  localparam logic [2:0] M_SGL  = 3'b111;

  // SAV status 0x300: field 1, vblank 0, start; EAV status 0x340: end
  localparam logic [9:0] STIM [N_STIM] = '{
    10'h3FF, 10'h000, 10'h000, 10'h300,
    10'h040, 10'h100, 10'h0C0, 10'h104,
    10'h044, 10'h108, 10'h0C4, 10'h10C,
    10'h3FF, 10'h000, 10'h000, 10'h340};
  // {c_is_cr, y, c, field, vblank, hflag}
  localparam logic [23:0] EXP [N_EXP] = '{
    {1'b0, 10'h100, 10'h040, 3'b100},
    {1'b1, 10'h104, 10'h0C0, 3'b100},
    {1'b0, 10'h108, 10'h044, 3'b100},
    {1'b1, 10'h10C, 10'h0C4, 3'b100}};

  logic          clk, rst_n;
  logic [2:0]    mode;
  logic          y_on_rise, narrow;
  logic [DW-1:0] data, y_o, c_o;
  logic          c_is_cr_o, valid_o, field_o, vblank_o, hflag_o;

  int checks = 0;
  int fails  = 0;
  logic [23:0] rec [16];
  int rec_n = 0;
  logic [9:0] seq [32];
  int seq_n = 0;

  ycbcr_ilv_demux #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .y_on_rise_i(y_on_rise),
    .narrow_i(narrow), .data_i(data), .y_o(y_o), .c_o(c_o),
    .c_is_cr_o(c_is_cr_o), .valid_o(valid_o), .field_o(field_o),
    .vblank_o(vblank_o), .hflag_o(hflag_o));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (rst_n && valid_o && rec_n < 16) begin
      rec[rec_n] = {c_is_cr_o, y_o, c_o, field_o, vblank_o, hflag_o};
      rec_n++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode = 3'b000; data = '0; y_on_rise = 1'b0; narrow = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rec_n = 0;
  endtask

  task automatic load_stim();
    for (int i = 0; i < N_STIM; i++) seq[i] = STIM[i];
    seq_n = N_STIM;
  endtask

  task automatic run_seq(input logic [2:0] m, input logic ysel, input logic nar,
                         input logic [9:0] orm);
    do_reset();
    y_on_rise = ysel;
    narrow    = nar;
    if (m == M_DUAL) begin
      for (int i = 0; i < seq_n; i += 2) begin
        if (!ysel) begin
          @(negedge clk); #1.25; data = seq[i] | orm; mode = m;
          @(posedge clk); #1.25; data = seq[i+1] | orm;
        end else begin
          @(posedge clk); #1.25; data = seq[i] | orm; mode = m;
          @(negedge clk); #1.25; data = seq[i+1] | orm;
        end
      end
    end else begin
      for (int i = 0; i < seq_n; i++) begin
        @(negedge clk); #1.25; data = seq[i] | orm; mode = m;
      end
    end
    @(negedge clk); #1.25; mode = 3'b000;
    repeat (6) @(posedge clk);
    #2;
  endtask

  task automatic check_table(input string req);
    chk(rec_n == N_EXP, req, rec_n, N_EXP);
    for (int i = 0; i < N_EXP; i++)
      chk(rec[i] == EXP[i], req, rec[i], EXP[i]);
    chk({field_o, vblank_o, hflag_o} == 3'b101, {req, " R5 final flags"},
        {field_o, vblank_o, hflag_o}, 3'b101);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(posedge clk); #1;
    // R10 reset state
    chk(valid_o == 1'b0, "R10 valid after reset", valid_o, 0);
    chk(c_is_cr_o == 1'b0, "R10 chroma select after reset", c_is_cr_o, 0);
    chk({field_o, vblank_o, hflag_o} == 3'b000, "R10 flags after reset",
        {field_o, vblank_o, hflag_o}, 0);

    // R1 R5 R6 R8 single-edge capture
    load_stim();
    run_seq(M_SGL, 1'b0, 1'b0, 10'h000);
    check_table("R1 R6 R8 single-edge");

    // R2 R3 dual-edge, chroma on rising edge
    load_stim();
    run_seq(M_DUAL, 1'b0, 1'b0, 10'h000);
    check_table("R2 R3 dual-edge chroma-rise");

    // R3 dual-edge, luma on rising edge
    load_stim();
    run_seq(M_DUAL, 1'b1, 1'b0, 10'h000);
    check_table("R3 dual-edge luma-rise");

    // R9 narrow bus: low bits driven high must vanish
    load_stim();
    run_seq(M_SGL, 1'b0, 1'b1, 10'h003);
    check_table("R9 narrow single-edge");

    // R4 unsupported mode captures nothing
    load_stim();
    run_seq(3'b101, 1'b0, 1'b0, 10'h000);
    chk(rec_n == 0, "R4 pulses in idle mode", rec_n, 0);
    chk({field_o, vblank_o, hflag_o} == 3'b000, "R4 flags in idle mode",
        {field_o, vblank_o, hflag_o}, 0);

    // R7 SAV resets sequencer; stray word checks R1 header realignment
    seq = '{default: 10'h000};
    seq[0]  = 10'h155;
    seq[1]  = 10'h3FF; seq[2]  = 10'h000; seq[3]  = 10'h000; seq[4]  = 10'h2C0;
    seq[5]  = 10'h080; seq[6]  = 10'h110;
    seq[7]  = 10'h3FF; seq[8]  = 10'h000; seq[9]  = 10'h000; seq[10] = 10'h280;
    seq[11] = 10'h050; seq[12] = 10'h120;
    seq_n = 13;
    run_seq(M_SGL, 1'b0, 1'b0, 10'h000);
    chk(rec_n == 2, "R1 R7 pulse count", rec_n, 2);
    chk(rec[0] == {1'b0, 10'h110, 10'h080, 3'b011}, "R5 pair after end code",
        rec[0], {1'b0, 10'h110, 10'h080, 3'b011});
    chk(rec[1] == {1'b0, 10'h120, 10'h050, 3'b010}, "R7 Cb after start code",
        rec[1], {1'b0, 10'h120, 10'h050, 3'b010});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule